// File: doc/BRIEF.md
# Adaptive Search-Key Sequencer

This block picks the 36-bit key that a thread-matching content-addressable store searches next. The key is twelve 3-bit angular-momentum fields. A short dictionary of frequent patterns is held in a parameter array. The sequencer fires the current dictionary word again and again for as long as each search returns enough hits. When the hit count for a search falls below a threshold, it moves to the next word. After the last word has fallen below the threshold, the sequencer stops guessing. It takes its next key from a thread that the store reports as unmatched, so every such search is certain to hit at least once.

The key goes out on a valid/ready request stream. A request, once raised, keeps its valid flag and its key unchanged until ready is seen. Only one request is outstanding at a time. After each handshake the sequencer raises `hit_ready_o` and waits for the hit count of that search on a valid/ready result stream. It decides the next key only after that count has returned. Unmatched keys arrive on a third valid/ready stream. When the store reports that it holds no unmatched thread at all, the sequencer goes back to the first dictionary word. A single `start_i` pulse launches the sequence from idle.

Top module: `sw_key_sequencer`

## Requirements
- R1: After reset, `srch_valid_o`, `hit_ready_o` and `seed_ready_o` are low, and they stay low until `start_i` is seen.
- R2: A `start_i` pulse while idle raises `srch_valid_o` on the next cycle, carrying dictionary word 0.
- R3: While `srch_valid_o` is high and `srch_ready_i` is low, `srch_valid_o` stays high and `srch_key_o` does not change.
- R4: After a request handshake, `srch_valid_o` stays low and `hit_ready_o` stays high until a hit count is accepted.
- R5: In dictionary mode, a returned hit count of at least `HIT_THRESH` (equality included) makes the next request carry the same key.
- R6: In dictionary mode, a returned hit count below `HIT_THRESH` makes the next request carry the next dictionary word.
- R7: A count below `HIT_THRESH` on the last dictionary word enters unmatched-key mode. In that mode no request is raised and `seed_ready_o` is high until an unmatched key is offered.
- R8: An unmatched key accepted while `seed_ready_o` is high becomes the key of the next request, one cycle later.
- R9: While `seed_ready_o` is high, `seed_none_i` high with `seed_valid_i` low makes the next request carry dictionary word 0. If both are high, the offered unmatched key wins.
- R10: Each unmatched key is searched once. Whatever hit count it returns, the sequencer then waits for a new unmatched key.
- R11: `start_i` has no effect once the sequence is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch pulse, honoured only when idle |
| srch_valid_o | output | 1 | Search request valid |
| srch_ready_i | input | 1 | Search request accepted |
| srch_key_o | output | 36 | Search key, twelve 3-bit momentum fields |
| hit_valid_i | input | 1 | Hit count for the last search is present |
| hit_ready_o | output | 1 | Waiting for a hit count |
| hit_count_i | input | 8 | Number of threads that matched the last search |
| seed_valid_i | input | 1 | An unmatched thread's key is offered |
| seed_ready_o | output | 1 | Ready to take an unmatched key |
| seed_key_i | input | 36 | Key of an unmatched thread |
| seed_none_i | input | 1 | The store holds no unmatched thread |

## Verification
Two decisions can fall due in the same cycle while the sequencer waits for an unmatched key. One is taking the offered key. The other is falling back to the dictionary because the store reports none. The bench raises `seed_valid_i` and `seed_none_i` together on one edge and expects the next request to carry the offered key, not dictionary word 0. A second case puts the threshold test and the end of the dictionary in the same result. A count exactly at the threshold on a word must refire that word, and a count one below it on the last word must switch to unmatched-key mode with no request raised.

// File: rtl/sw_ctrl_pkg.sv
package sw_ctrl_pkg;
  typedef enum logic [1:0] {
    SW_IDLE = 2'd0,
    SW_DICT = 2'd1,
    SW_SEED = 2'd2
  } sw_mode_e;
endpackage

// File: rtl/sw_dict_rom.sv
module sw_dict_rom #(
  parameter int KEY_W = 36,
  parameter int DEPTH = 4,
  parameter int IDX_W = 2,
  parameter logic [KEY_W-1:0] WORDS [DEPTH] = '{default: '0}
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [KEY_W-1:0] word_o
);
  logic [KEY_W-1:0] lane [DEPTH];

  // one gated lane per entry, merged by OR
  for (genvar g = 0; g < DEPTH; g++) begin : g_lane
    assign lane[g] = (idx_i == IDX_W'(g)) ? WORDS[g] : '0;
  end

  always_comb begin
    word_o = '0;
    for (int k = 0; k < DEPTH; k++) word_o = word_o | lane[k];
  end
endmodule

// File: rtl/sw_hit_judge.sv
module sw_hit_judge #(
  parameter int CNT_W  = 8,
  parameter int THRESH = 8
) (
  input  logic [CNT_W-1:0] count_i,
  output logic             keep_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(THRESH);
  assign keep_o = (count_i >= LIMIT);
endmodule

// File: rtl/sw_req_port.sv
module sw_req_port #(
  parameter int KEY_W = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [KEY_W-1:0] load_key_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [KEY_W-1:0] key_o,
  output logic             fire_o
);
  assign fire_o = valid_o & ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      key_o   <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      key_o   <= load_key_i;
    end else if (fire_o) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sw_key_sequencer.sv
module sw_key_sequencer
  import sw_ctrl_pkg::*;
#(
  parameter int MOM_W      = 3,
  parameter int MOM_N      = 12,
  parameter int DICT_DEPTH = 4,
  parameter int CNT_W      = 8,
  parameter int HIT_THRESH = 8,
  parameter logic [MOM_W*MOM_N-1:0] DICT_WORDS [DICT_DEPTH] = '{
    36'o100000000000, 36'o110000000000, 36'o111000000000, 36'o210000000000}
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  output logic                   srch_valid_o,
  input  logic                   srch_ready_i,
  output logic [MOM_W*MOM_N-1:0] srch_key_o,
  input  logic                   hit_valid_i,
  output logic                   hit_ready_o,
  input  logic [CNT_W-1:0]       hit_count_i,
  input  logic                   seed_valid_i,
  output logic                   seed_ready_o,
  input  logic [MOM_W*MOM_N-1:0] seed_key_i,
  input  logic                   seed_none_i
);
  localparam int KEY_W = MOM_W * MOM_N;
  localparam int IDX_W = (DICT_DEPTH > 1) ? $clog2(DICT_DEPTH) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DICT_DEPTH - 1);

  sw_mode_e         mode_q, mode_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             wait_q, wait_d;
  logic             load, seed_pick, fire, keep, hit_take;
  logic [KEY_W-1:0] rom_word, load_key;

  sw_dict_rom #(.KEY_W(KEY_W), .DEPTH(DICT_DEPTH), .IDX_W(IDX_W), .WORDS(DICT_WORDS)) u_rom (
    .idx_i (idx_d),
    .word_o(rom_word)
  );

  sw_hit_judge #(.CNT_W(CNT_W), .THRESH(HIT_THRESH)) u_judge (
    .count_i(hit_count_i),
    .keep_o (keep)
  );

  sw_req_port #(.KEY_W(KEY_W)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .load_key_i(load_key),
    .ready_i   (srch_ready_i),
    .valid_o   (srch_valid_o),
    .key_o     (srch_key_o),
    .fire_o    (fire)
  );

  assign hit_ready_o  = wait_q;
  assign hit_take     = wait_q & hit_valid_i;
  assign seed_ready_o = (mode_q == SW_SEED) && !srch_valid_o && !wait_q;
  assign load_key     = seed_pick ? seed_key_i : rom_word;

  always_comb begin
    mode_d    = mode_q;
    idx_d     = idx_q;
    wait_d    = wait_q;
    load      = 1'b0;
    seed_pick = 1'b0;
    unique case (mode_q)
      SW_IDLE: begin
        if (start_i) begin
          mode_d = SW_DICT;
          idx_d  = '0;
          load   = 1'b1;
        end
      end
      SW_DICT: begin
        if (hit_take) begin
          wait_d = 1'b0;
          if (keep) begin
            load = 1'b1;
          end else if (idx_q == LAST_IDX) begin
            mode_d = SW_SEED;
          end else begin
            idx_d = idx_q + IDX_W'(1);
            load  = 1'b1;
          end
        end
      end
      SW_SEED: begin
        if (hit_take) begin
          wait_d = 1'b0;
        end else if (seed_ready_o) begin
          if (seed_valid_i) begin
            load      = 1'b1;
            seed_pick = 1'b1;
          end else if (seed_none_i) begin
            mode_d = SW_DICT;
            idx_d  = '0;
            load   = 1'b1;
          end
        end
      end
      default: mode_d = SW_IDLE;
    endcase
    if (fire) wait_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= SW_IDLE;
      idx_q  <= '0;
      wait_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      idx_q  <= idx_d;
      wait_q <= wait_d;
    end
  end
endmodule

// File: rtl/sw_key_sequencer_chk.sv
module sw_key_sequencer_chk
  import sw_ctrl_pkg::*;
#(
  parameter int KEY_W      = 36,
  parameter int CNT_W      = 8,
  parameter int HIT_THRESH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             srch_valid_o,
  input logic             srch_ready_i,
  input logic [KEY_W-1:0] srch_key_o,
  input logic             hit_valid_i,
  input logic             hit_ready_o,
  input logic [CNT_W-1:0] hit_count_i,
  input logic             seed_valid_i,
  input logic             seed_ready_o,
  input logic [KEY_W-1:0] seed_key_i,
  input sw_mode_e         mode_q
);
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_valid_o && !srch_ready_i) |=> (srch_valid_o && $stable(srch_key_o)));

  // R4
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srch_valid_o |-> !hit_ready_o);

  // R5
  refire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_ready_o && hit_valid_i && (hit_count_i >= CNT_W'(HIT_THRESH)) && mode_q == SW_DICT)
      |=> (srch_valid_o && srch_key_o == $past(srch_key_o)));

  // R8
  seed_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_valid_i && seed_ready_o) |=> (srch_valid_o && srch_key_o == $past(seed_key_i)));

  // R7
  seed_wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seed_ready_o |-> (!srch_valid_o && !hit_ready_o));
endmodule

bind sw_key_sequencer sw_key_sequencer_chk #(
  .KEY_W(KEY_W), .CNT_W(CNT_W), .HIT_THRESH(HIT_THRESH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .srch_valid_o(srch_valid_o), .srch_ready_i(srch_ready_i),
  .srch_key_o(srch_key_o), .hit_valid_i(hit_valid_i), .hit_ready_o(hit_ready_o),
  .hit_count_i(hit_count_i), .seed_valid_i(seed_valid_i), .seed_ready_o(seed_ready_o),
  .seed_key_i(seed_key_i), .mode_q(mode_q)
);

// File: tb/sim_sw_key_sequencer.sv
module sim_sw_key_sequencer;
  localparam int CLK_P = 10;
  localparam logic [35:0] W0 = 36'o200000000000;
  localparam logic [35:0] W1 = 36'o220000000000;
  localparam logic [35:0] W2 = 36'o111100000000;
  localparam logic [35:0] W3 = 36'o321000000000;
  localparam logic [35:0] S1 = 36'o765432101234;
  localparam logic [35:0] S2 = 36'o070707070707;
  localparam int NV = 7;
  // presented key, hit count returned, cycles of ready held low
  localparam logic [35:0] TV_KEY [NV] = '{W0, W0, W0, W1, W2, W2, W3};
  localparam int TV_HIT [NV] = '{10, 8, 7, 0, 20, 3, 7};
  localparam int TV_STALL [NV] = '{0, 2, 0, 1, 0, 0, 3};

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic srch_valid_o, srch_ready_i = 1'b0;
  logic [35:0] srch_key_o;
  logic hit_valid_i = 1'b0, hit_ready_o;
  logic [7:0] hit_count_i = '0;
  logic seed_valid_i = 1'b0, seed_ready_o, seed_none_i = 1'b0;
  logic [35:0] seed_key_i = '0;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sw_key_sequencer #(.DICT_WORDS('{W0, W1, W2, W3})) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .srch_valid_o(srch_valid_o), .srch_ready_i(srch_ready_i), .srch_key_o(srch_key_o),
    .hit_valid_i(hit_valid_i), .hit_ready_o(hit_ready_o), .hit_count_i(hit_count_i),
    .seed_valid_i(seed_valid_i), .seed_ready_o(seed_ready_o), .seed_key_i(seed_key_i),
    .seed_none_i(seed_none_i)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  // serve one search: expect a key, stall ready, then return a hit count
  task automatic serve(input logic [35:0] exp_key, input int stall, input int hits, input string rq);
    int w = 0;
    while (!srch_valid_o && w < 50) begin
      @(negedge clk);
      w++;
    end
    chk(srch_valid_o, rq, 64'(srch_valid_o), 64'd1);
    chk(srch_key_o == exp_key, rq, 64'(srch_key_o), 64'(exp_key));
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(srch_valid_o && srch_key_o == exp_key, "R3", 64'(srch_key_o), 64'(exp_key));
    end
    srch_ready_i = 1'b1;
    @(negedge clk);
    srch_ready_i = 1'b0;
    chk(!srch_valid_o && hit_ready_o, "R4", {62'd0, srch_valid_o, hit_ready_o}, 64'd1);
    @(negedge clk);
    chk(!srch_valid_o && hit_ready_o, "R4", {62'd0, srch_valid_o, hit_ready_o}, 64'd1);
    hit_valid_i = 1'b1;
    hit_count_i = 8'(hits);
    @(negedge clk);
    hit_valid_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1..R11 act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: quiet after reset without start
    chk(!srch_valid_o && !hit_ready_o && !seed_ready_o, "R1",
        {61'd0, srch_valid_o, hit_ready_o, seed_ready_o}, 64'd0);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R2: first word one cycle after start
    chk(srch_valid_o && srch_key_o == W0, "R2", 64'(srch_key_o), 64'(W0));

    // dictionary walk: R5 refire at/above threshold, R6 advance below, R7 end
    for (int i = 0; i < NV; i++) begin
      serve(TV_KEY[i], TV_STALL[i], TV_HIT[i], (i > 0 && TV_HIT[i-1] >= 8) ? "R5" : "R6");
    end

    // R7: unmatched-key mode, nothing requested
    chk(!srch_valid_o && seed_ready_o, "R7", {62'd0, srch_valid_o, seed_ready_o}, 64'd1);
    repeat (3) @(negedge clk);
    chk(!srch_valid_o && seed_ready_o, "R7", {62'd0, srch_valid_o, seed_ready_o}, 64'd1);

    // R8: offered key becomes the request
    seed_valid_i = 1'b1;
    seed_key_i = S1;
    #1 chk(seed_ready_o, "R8", 64'(seed_ready_o), 64'd1);
    @(negedge clk);
    seed_valid_i = 1'b0;
    chk(srch_valid_o && srch_key_o == S1, "R8", 64'(srch_key_o), 64'(S1));
    serve(S1, 1, 50, "R8");

    // R10: high count still means a fresh unmatched key
    chk(!srch_valid_o && seed_ready_o, "R10", {62'd0, srch_valid_o, seed_ready_o}, 64'd1);

    // R9: both offered and none at once, the offered key wins
    seed_valid_i = 1'b1;
    seed_none_i = 1'b1;
    seed_key_i = S2;
    @(negedge clk);
    seed_valid_i = 1'b0;
    seed_none_i = 1'b0;
    chk(srch_valid_o && srch_key_o == S2, "R9", 64'(srch_key_o), 64'(S2));
    serve(S2, 0, 0, "R9");

    // R9: none alone restarts the dictionary
    seed_none_i = 1'b1;
    @(negedge clk);
    seed_none_i = 1'b0;
    chk(srch_valid_o && srch_key_o == W0, "R9", 64'(srch_key_o), 64'(W0));

    // R11: start while running has no effect
    start_i = 1'b1;
    serve(W0, 2, 0, "R9");
    start_i = 1'b0;
    serve(W1, 0, 9, "R11");
    serve(W1, 0, 0, "R5");

    // R1: reset mid-run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!srch_valid_o && !hit_ready_o && !seed_ready_o, "R1",
        {61'd0, srch_valid_o, hit_ready_o, seed_ready_o}, 64'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule